// File: doc/BRIEF.md
# CPU Clock Transition Sequencer

This block moves a processor core clock from its present performance level to a requested one, choosing among sixteen levels. Level 0 runs at 1700 MHz and each step up in index is 100 MHz slower, ending at 200 MHz for level 15. A requester presents a target level with a valid/ready handshake. The block looks up the PLL and divider settings for that level in an internal table. It then performs the register writes and status waits needed to reach the level: switching the core clock mux, loading the PLL lock counter, writing the PLL word and writing two divider words.

The order of the steps depends on the request. When the clock speeds up (lower target index), the PLL is reprogrammed first and the dividers follow. When the clock slows down, the dividers are changed first. If the old and new levels share the same multiplier and predivider, only the postdivider is rewritten. In that case the mux is not touched and no lock is awaited. Every wait is bounded by a programmable timeout. An expired wait raises a sticky error and abandons the request. The current level is kept as it was, and the block becomes ready again.

Top module: `core_clk_seq`

## Requirements
- R1: After reset, req_ready is 1, cur_level is 9, err, done and mux_alt are 0, and no write strobe (lock_we, pll_we, div0_we, div1_we) is high.
- R2: pll_word carries the target level's multiplier in bits 25:16, predivider in bits 13:8 and postdivider in bits 2:0, with all other bits 0. The multiplier/predivider/postdivider values are as follows. Levels 0 to 9: 425/6/0, 200/3/0, 250/4/0, 175/3/0, 325/6/0, 200/4/0, 275/6/0, 125/3/0, 150/4/0, 100/3/0. Levels 10 to 15: 175/3/1, 200/4/1, 125/3/1, 100/3/1, 200/4/2, 100/3/2.
- R3: A request whose target equals cur_level completes with a done pulse and produces no write strobe and no mux change.
- R4: A full PLL change performs these steps in order: set mux_alt to 1; wait for mux_status to equal 2; pulse lock_we with lock_val equal to predivider times 250; pulse pll_we; wait for pll_locked; clear mux_alt; wait for mux_status to equal 1. For a speed-up, these steps come before the divider update.
- R5: For a slow-down that needs a full PLL change, the divider update comes first and the full PLL change from R4 follows.
- R6: When old and new levels have equal multiplier and predivider, the PLL work is a single pll_we pulse with no mux change and no lock_we. This pulse comes before the divider update on a speed-up and after it on a slow-down.
- R7: The divider update pulses div0_we, then waits until bit 0 of every nibble of div0_busy is clear. It then pulses div1_we and waits until bits 0 and 4 of div1_busy are clear. All other busy bits are ignored.
- R8: req_ready is low from the accepting edge until done. done is high for exactly one cycle and req_ready is high in the next cycle. cur_level takes the target value in that next cycle and changes at no other time.
- R9: If a wait is not satisfied within tmo_limit+1 cycles, err becomes 1 and stays 1 until reset. The block returns to ready without a done pulse, and cur_level keeps its old value.
- R10: At most one of lock_we, pll_we, div0_we and div1_we is high in any cycle.
- R11: Per level, div0_word holds 0 in bits 31:28 and 3:0 and holds 7 in bits 15:12 and 11:8. Bits 7:4 are 3,3,2,2,2,2,3 for levels 0 to 6 and 1 above. Bits 19:16 are 7,7,7,6,6,5,5,4,4,4,3,3,2,2,1,1. Bits 23:20 are 3 at level 0 and 1 elsewhere. Bits 27:24 are 5,4,4,4,3,3,3,2,2,2 for levels 0 to 9 and 1 above. div1_word is 32'h20 for every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_level | input | 4 | Target level index |
| req_ready | output | 1 | Block can accept a request |
| tmo_limit | input | 16 | Timeout limit for each wait, in cycles |
| mux_status | input | 3 | Core mux status (1 = main PLL, 2 = alternate PLL) |
| pll_locked | input | 1 | PLL lock flag |
| div0_busy | input | 32 | First divider busy status |
| div1_busy | input | 32 | Second divider busy status |
| mux_alt | output | 1 | Core mux selects the alternate PLL when 1 |
| lock_we | output | 1 | Lock counter write strobe |
| lock_val | output | 16 | Lock counter value |
| pll_we | output | 1 | PLL word write strobe |
| pll_word | output | 32 | PLL setting word |
| div0_we | output | 1 | First divider word write strobe |
| div0_word | output | 32 | First divider word |
| div1_we | output | 1 | Second divider word write strobe |
| div1_word | output | 32 | Second divider word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |
| cur_level | output | 4 | Current level index |

## Verification
A wrong direction or relock decision taken at acceptance becomes visible at the ports within the first one or two cycles of the sequence. It shows up as a wrong first strobe or a wrong mux edge, so the order of write strobes and mux edges is recorded and compared for every one of the 256 pairs of old and new levels. A wrong table entry or a stale lookup address shows up on the data bus during the first strobe that uses it. A level register updated at the wrong moment or to the wrong value shows up on cur_level in the cycle after done. Any wait state that does not test the right status bits either hangs the sequence or finishes it too early. The status model raises unrelated busy bits to expose such faults.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef struct packed {
    logic [9:0] m;
    logic [5:0] p;
    logic [2:0] s;
    logic [3:0] cpud;
    logic [3:0] atb;
    logic [3:0] dbg;
    logic [3:0] plr;
  } lvl_cfg_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MUX_ALT, ST_MUX_ALT_W, ST_LOCK_LD, ST_PLL_WR, ST_LOCK_W,
    ST_MUX_MAIN, ST_MUX_MAIN_W, ST_S_WR, ST_DIV0_WR, ST_DIV0_W,
    ST_DIV1_WR, ST_DIV1_W, ST_FIN
  } seq_state_t;

  // Settings per performance level: PLL multiplier, predivider, postdivider,
  // then the four varying divider ratios.
  function automatic lvl_cfg_t lvl_cfg(input logic [3:0] lvl);
    lvl_cfg_t c;
    case (lvl)
      4'd0:  c = '{10'd425, 6'd6, 3'd0, 4'd3, 4'd7, 4'd3, 4'd5};
      4'd1:  c = '{10'd200, 6'd3, 3'd0, 4'd3, 4'd7, 4'd1, 4'd4};
      4'd2:  c = '{10'd250, 6'd4, 3'd0, 4'd2, 4'd7, 4'd1, 4'd4};
      4'd3:  c = '{10'd175, 6'd3, 3'd0, 4'd2, 4'd6, 4'd1, 4'd4};
      4'd4:  c = '{10'd325, 6'd6, 3'd0, 4'd2, 4'd6, 4'd1, 4'd3};
      4'd5:  c = '{10'd200, 6'd4, 3'd0, 4'd2, 4'd5, 4'd1, 4'd3};
      4'd6:  c = '{10'd275, 6'd6, 3'd0, 4'd3, 4'd5, 4'd1, 4'd3};
      4'd7:  c = '{10'd125, 6'd3, 3'd0, 4'd1, 4'd4, 4'd1, 4'd2};
      4'd8:  c = '{10'd150, 6'd4, 3'd0, 4'd1, 4'd4, 4'd1, 4'd2};
      4'd9:  c = '{10'd100, 6'd3, 3'd0, 4'd1, 4'd4, 4'd1, 4'd2};
      4'd10: c = '{10'd175, 6'd3, 3'd1, 4'd1, 4'd3, 4'd1, 4'd1};
      4'd11: c = '{10'd200, 6'd4, 3'd1, 4'd1, 4'd3, 4'd1, 4'd1};
      4'd12: c = '{10'd125, 6'd3, 3'd1, 4'd1, 4'd2, 4'd1, 4'd1};
      4'd13: c = '{10'd100, 6'd3, 3'd1, 4'd1, 4'd2, 4'd1, 4'd1};
      4'd14: c = '{10'd200, 6'd4, 3'd2, 4'd1, 4'd1, 4'd1, 4'd1};
      default: c = '{10'd100, 6'd3, 3'd2, 4'd1, 4'd1, 4'd1, 4'd1};
    endcase
    return c;
  endfunction

  function automatic logic [31:0] pack_pll(input lvl_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[25:16] = c.m;
    w[13:8]  = c.p;
    w[2:0]   = c.s;
    return w;
  endfunction

  function automatic logic [31:0] pack_div0(input lvl_cfg_t c);
    return {4'd0, c.plr, c.dbg, c.atb, 4'd7, 4'd7, c.cpud, 4'd0};
  endfunction

endpackage

// File: rtl/pcs_settings.sv
module pcs_settings
  import pcs_pkg::*;
#(
  parameter int LEVELS = 16,
  parameter int LVL_W  = $clog2(LEVELS),
  parameter int WORD_W = 32,
  parameter int LOCK_W = 16,
  parameter int LOCK_MUL = 250
) (
  input  logic              clk,
  input  logic [LVL_W-1:0]  rd_addr,
  input  logic [LVL_W-1:0]  cmp_a,
  input  logic [LVL_W-1:0]  cmp_b,
  output logic              pm_same,
  output logic [WORD_W-1:0] pll_q,
  output logic [WORD_W-1:0] div0_q,
  output logic [WORD_W-1:0] div1_q,
  output logic [LOCK_W-1:0] lock_q
);
  localparam logic [WORD_W-1:0] DIV1_CONST = WORD_W'(32'h20);

  logic [WORD_W-1:0] pll_rom  [LEVELS];
  logic [WORD_W-1:0] div0_rom [LEVELS];
  logic [LOCK_W-1:0] lock_rom [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_rom
    localparam lvl_cfg_t CFG = lvl_cfg(4'(g));
    assign pll_rom[g]  = WORD_W'(pack_pll(CFG));
    assign div0_rom[g] = WORD_W'(pack_div0(CFG));
    assign lock_rom[g] = LOCK_W'(CFG.p) * LOCK_W'(LOCK_MUL);
  end

  // Multiplier and predivider occupy bits 25:8 of the PLL word.
  assign pm_same = (pll_rom[cmp_a][25:8] == pll_rom[cmp_b][25:8]);

  always_ff @(posedge clk) begin
    pll_q  <= pll_rom[rd_addr];
    div0_q <= div0_rom[rd_addr];
    div1_q <= DIV1_CONST;
    lock_q <= lock_rom[rd_addr];
  end
endmodule

// File: rtl/pcs_wait_timer.sv
module pcs_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/core_clk_seq.sv
module core_clk_seq
  import pcs_pkg::*;
#(
  parameter int LEVELS    = 16,
  parameter int LVL_W     = $clog2(LEVELS),
  parameter int TMO_W     = 16,
  parameter int WORD_W    = 32,
  parameter int LOCK_W    = 16,
  parameter int SAFE_LVL  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LVL_W-1:0]  req_level,
  output logic              req_ready,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [2:0]        mux_status,
  input  logic              pll_locked,
  input  logic [WORD_W-1:0] div0_busy,
  input  logic [WORD_W-1:0] div1_busy,
  output logic              mux_alt,
  output logic              lock_we,
  output logic [LOCK_W-1:0] lock_val,
  output logic              pll_we,
  output logic [WORD_W-1:0] pll_word,
  output logic              div0_we,
  output logic [WORD_W-1:0] div0_word,
  output logic              div1_we,
  output logic [WORD_W-1:0] div1_word,
  output logic              done,
  output logic              err
  ,output logic [LVL_W-1:0] cur_level
);
  localparam logic [WORD_W-1:0] DIV0_BUSY_MASK = WORD_W'(32'h1111_1111);
  localparam logic [WORD_W-1:0] DIV1_BUSY_MASK = WORD_W'(32'h0000_0011);
  localparam logic [2:0]        MUX_ON_MAIN    = 3'd1;
  localparam logic [2:0]        MUX_ON_ALT     = 3'd2;

  seq_state_t st, st_n;
  logic [LVL_W-1:0] tgt;
  logic             up, relock, pm_same, accept;
  logic             in_wait, wait_met, expired, fault;
  seq_state_t       pll_end, div_end;

  pcs_settings #(.LEVELS(LEVELS), .LVL_W(LVL_W), .WORD_W(WORD_W), .LOCK_W(LOCK_W)) u_tab (
    .clk(clk), .rd_addr(accept ? req_level : tgt), .cmp_a(req_level), .cmp_b(cur_level),
    .pm_same(pm_same), .pll_q(pll_word), .div0_q(div0_word), .div1_q(div1_word), .lock_q(lock_val)
  );

  pcs_wait_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst(rst), .run(in_wait), .limit(tmo_limit), .expired(expired)
  );

  assign accept  = req_valid && (st == ST_IDLE);
  assign pll_end = up ? ST_DIV0_WR : ST_FIN;
  assign div_end = up ? ST_FIN : (relock ? ST_MUX_ALT : ST_S_WR);

  always_comb begin
    in_wait  = 1'b1;
    wait_met = 1'b0;
    case (st)
      ST_MUX_ALT_W:  wait_met = (mux_status == MUX_ON_ALT);
      ST_LOCK_W:     wait_met = pll_locked;
      ST_MUX_MAIN_W: wait_met = (mux_status == MUX_ON_MAIN);
      ST_DIV0_W:     wait_met = ((div0_busy & DIV0_BUSY_MASK) == '0);
      ST_DIV1_W:     wait_met = ((div1_busy & DIV1_BUSY_MASK) == '0);
      default:       in_wait  = 1'b0;
    endcase
  end

  assign fault = in_wait && !wait_met && expired;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE: if (req_valid) begin
        if (req_level == cur_level)     st_n = ST_FIN;
        else if (req_level < cur_level) st_n = pm_same ? ST_S_WR : ST_MUX_ALT;
        else                            st_n = ST_DIV0_WR;
      end
      ST_MUX_ALT:    st_n = ST_MUX_ALT_W;
      ST_MUX_ALT_W:  st_n = wait_met ? ST_LOCK_LD : (fault ? ST_IDLE : st);
      ST_LOCK_LD:    st_n = ST_PLL_WR;
      ST_PLL_WR:     st_n = ST_LOCK_W;
      ST_LOCK_W:     st_n = wait_met ? ST_MUX_MAIN : (fault ? ST_IDLE : st);
      ST_MUX_MAIN:   st_n = ST_MUX_MAIN_W;
      ST_MUX_MAIN_W: st_n = wait_met ? pll_end : (fault ? ST_IDLE : st);
      ST_S_WR:       st_n = pll_end;
      ST_DIV0_WR:    st_n = ST_DIV0_W;
      ST_DIV0_W:     st_n = wait_met ? ST_DIV1_WR : (fault ? ST_IDLE : st);
      ST_DIV1_WR:    st_n = ST_DIV1_W;
      ST_DIV1_W:     st_n = wait_met ? div_end : (fault ? ST_IDLE : st);
      ST_FIN:        st_n = ST_IDLE;
      default:       st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur_level <= LVL_W'(SAFE_LVL);
      tgt       <= LVL_W'(SAFE_LVL);
      up        <= 1'b0;
      relock    <= 1'b0;
      err       <= 1'b0;
      mux_alt   <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        tgt    <= req_level;
        up     <= (req_level < cur_level);
        relock <= !pm_same;
      end
      if (st == ST_FIN)      cur_level <= tgt;
      if (fault)             err       <= 1'b1;
      if (st == ST_MUX_ALT)  mux_alt   <= 1'b1;
      if (st == ST_MUX_MAIN) mux_alt   <= 1'b0;
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign lock_we   = (st == ST_LOCK_LD);
  assign pll_we    = (st == ST_PLL_WR) || (st == ST_S_WR);
  assign div0_we   = (st == ST_DIV0_WR);
  assign div1_we   = (st == ST_DIV1_WR);
  assign done      = (st == ST_FIN);

  assert_one_write_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lock_we, pll_we, div0_we, div1_we}));

  assert_lock_on_alt_R4: assert property (@(posedge clk) disable iff (rst)
    lock_we |-> mux_alt);

  assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cur_level != $past(cur_level)) |-> $past(done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: tb/sim_core_clk_seq.sv
module sim_core_clk_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        req_valid = 1'b0;
  logic [3:0]  req_level = '0;
  logic        req_ready;
  logic [15:0] tmo_limit = 16'd100;
  logic [2:0]  mux_status = 3'd1;
  logic        pll_locked = 1'b1;
  logic [31:0] div0_busy = 32'hEEEE_EEEE;
  logic [31:0] div1_busy = 32'hEE;
  logic        mux_alt, lock_we, pll_we, div0_we, div1_we, done, err;
  logic [15:0] lock_val;
  logic [31:0] pll_word, div0_word, div1_word;
  logic [3:0]  cur_level;

  core_clk_seq u0 (.*);

  int bm  [16] = '{425,200,250,175,325,200,275,125,150,100,175,200,125,100,200,100};
  int bp  [16] = '{6,3,4,3,6,4,6,3,4,3,3,4,3,3,4,3};
  int bs  [16] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,2,2};
  int bcd [16] = '{3,3,2,2,2,2,3,1,1,1,1,1,1,1,1,1};
  int batb[16] = '{7,7,7,6,6,5,5,4,4,4,3,3,2,2,1,1};
  int bdbg[16] = '{3,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1};
  int bpr [16] = '{5,4,4,4,3,3,3,2,2,2,1,1,1,1,1,1};

  int tests = 0, fails = 0;
  int dly = 0, cur_m = 9, tgt_m = 9, vbad = 0, cyc = 0;
  bit rec = 0, stuck_lock = 0, mux_prev = 0;
  logic [31:0] ev = '0;
  int mcnt = 0, lcnt = 0, d0cnt = 0, d1cnt = 0;

  function automatic logic [31:0] exp_pll(int l);
    return (32'(bm[l]) << 16) | (32'(bp[l]) << 8) | 32'(bs[l]);
  endfunction

  function automatic logic [31:0] exp_div0(int l);
    return (32'(bpr[l]) << 24) | (32'(bdbg[l]) << 20) | (32'(batb[l]) << 16) |
           32'h7700 | (32'(bcd[l]) << 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Status model and event recorder, both away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rec) begin
      if (mux_alt && !mux_prev) ev = (ev << 4) | 32'h1;
      if (!mux_alt && mux_prev) ev = (ev << 4) | 32'h4;
      if (lock_we) begin
        ev = (ev << 4) | 32'h2;
        if (lock_val != 16'(bp[tgt_m] * 250)) vbad++;
      end
      if (pll_we) begin
        ev = (ev << 4) | 32'h3;
        if (pll_word != exp_pll(tgt_m)) vbad++;
      end
      if (div0_we) begin
        ev = (ev << 4) | 32'h5;
        if (div0_word != exp_div0(tgt_m)) vbad++;
      end
      if (div1_we) begin
        ev = (ev << 4) | 32'h6;
        if (div1_word != 32'h20) vbad++;
      end
    end
    mux_prev = mux_alt;
    if (mux_status != (mux_alt ? 3'd2 : 3'd1)) begin
      if (mcnt >= dly) begin mux_status = mux_alt ? 3'd2 : 3'd1; mcnt = 0; end
      else mcnt++;
    end
    if (pll_we) begin pll_locked = 1'b0; lcnt = 0; end
    else if (!pll_locked && !stuck_lock) begin
      if (lcnt >= dly) pll_locked = 1'b1; else lcnt++;
    end
    if (div0_we) begin div0_busy = 32'hFFFF_FFFF; d0cnt = 0; end
    else if ((div0_busy & 32'h1111_1111) != 0) begin
      if (d0cnt >= dly) div0_busy = 32'hEEEE_EEEE; else d0cnt++;
    end
    if (div1_we) begin div1_busy = 32'hFF; d1cnt = 0; end
    else if ((div1_busy & 32'h11) != 0) begin
      if (d1cnt >= dly) div1_busy = 32'hEE; else d1cnt++;
    end
  end

  task automatic do_req(input int t);
    int n;
    bit rdy_low, relock, seen;
    logic [31:0] xev;
    while (!req_ready) @(negedge clk);
    relock = (bm[t] != bm[cur_m]) || (bp[t] != bp[cur_m]);
    if (t == cur_m)    xev = 32'h0;
    else if (t < cur_m) xev = relock ? 32'h123456 : 32'h356;
    else                xev = relock ? 32'h561234 : 32'h563;
    tgt_m = t; ev = '0; vbad = 0; rec = 1;
    req_valid = 1'b1; req_level = 4'(t);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; rdy_low = 1;
    while (!done && n < 400) begin
      if (req_ready) rdy_low = 0;
      @(negedge clk);
      n++;
    end
    seen = done;
    rec = 0;
    if (t == cur_m)
      chk(ev == xev, "R3 same level no activity", 64'(ev), 64'(xev));
    else if (!relock)
      chk(ev == xev, "R6 postdivider-only order", 64'(ev), 64'(xev));
    else if (t < cur_m)
      chk(ev == xev, "R4 speed-up relock order", 64'(ev), 64'(xev));
    else
      chk(ev == xev, "R5 slow-down relock order", 64'(ev), 64'(xev));
    chk(vbad == 0, "R2 R11 R7 write data", 64'(vbad), 64'd0);
    chk(seen && rdy_low, "R8 ready low until done", {62'd0, seen, rdy_low}, 64'd3);
    @(negedge clk);
    chk(!done && req_ready && cur_level == 4'(t), "R8 done pulse and level",
        {done, req_ready, cur_level}, {2'b01, 4'(t)});
    cur_m = t;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(cur_level === 4'd9, "R1 level after reset", 64'(cur_level), 64'd9);
    chk(err === 1'b0 && done === 1'b0 && mux_alt === 1'b0, "R1 flags after reset",
        {err, done, mux_alt}, 64'd0);
    chk({lock_we, pll_we, div0_we, div1_we} === 4'd0, "R1 R10 strobes after reset",
        64'({lock_we, pll_we, div0_we, div1_we}), 64'd0);
    // Sweep every ordered pair of levels.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        dly = (a + b) % 4;
        if (cur_m != a) do_req(a);
        do_req(b);
      end
    end
    // Timeout: lock never arrives on a speed-up that needs a relock.
    begin
      int n;
      bit seen_done;
      int old;
      old = cur_m;
      stuck_lock = 1; tmo_limit = 16'd6; dly = 1;
      while (!req_ready) @(negedge clk);
      tgt_m = 0; ev = '0; rec = 1;
      req_valid = 1'b1; req_level = 4'd0;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0; seen_done = 0;
      while (!req_ready && n < 200) begin
        if (done) seen_done = 1;
        @(negedge clk);
        n++;
      end
      rec = 0;
      chk(err === 1'b1, "R9 error on timeout", 64'(err), 64'd1);
      chk(!seen_done && req_ready, "R9 no done, ready again", {seen_done, req_ready}, 64'd1);
      chk(cur_level == 4'(old), "R9 level kept", 64'(cur_level), 64'(old));
      chk(ev == 32'h123, "R9 steps before stalled lock", 64'(ev), 64'h123);
      stuck_lock = 0; tmo_limit = 16'd100;
      do_req(old);
      chk(err === 1'b1, "R9 error sticky", 64'(err), 64'd1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cyc < 150000) @(negedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule